// File: doc/BRIEF.md
# Split-Target Branch Target Buffer

This block predicts the target address of a taken branch from the fetch PC. To save storage it keeps each target in two pieces. A primary set-associative table keyed by the PC holds the low-order target bits, a partial tag and a far flag. A smaller set-associative secondary table holds only high-order target bits and its own tag.

Most branches land near their own address. For these the far flag is clear, and the high part of the target is taken from the fetch PC itself. Only branches that cross a high-order boundary use a secondary entry. Both tables are read in the same cycle as a lookup, and the result is registered.

Resolved branches are written through a separate update port. The update decides the far flag by comparing the high bits of the target and of the branch PC, overwrites a matching entry in place, or replaces the least recently used way of the set. Table geometry, tag widths and the low/high split point are parameters.

Top module: `btb_split_target`

## Requirements
- R1: Reset clears every valid bit in both tables, so the output `lk_hit_o` is 0 during reset and every lookup misses until an entry is written.
- R2: A lookup presented with `lk_en_i` high at a clock edge has its result on `lk_hit_o`/`lk_tgt_o` after that edge. `lk_en_i` low gives `lk_hit_o` = 0, and any miss drives `lk_tgt_o` to zero.
- R3: An update whose target bits [ADDR_W-1:LO_W] equal the branch PC bits [ADDR_W-1:LO_W] is stored as near. A later hitting lookup then returns {lookup PC[ADDR_W-1:LO_W], stored target[LO_W-1:0]}.
- R4: An update whose high bits differ is stored as far, and its high bits go to the secondary table. A later lookup of that PC returns the full stored target.
- R5: A far primary entry hits only while the secondary set (PC[SIDX_W-1:0]) still holds a way tagged PC[SIDX_W +: S_TAG_W]. Otherwise the lookup misses.
- R6: The primary set is PC[PIDX_W-1:0] and the primary tag is PC[PIDX_W +: P_TAG_W]. PCs that differ only above those bits share one entry.
- R7: An update whose PC matches a valid entry overwrites that way in place and leaves the other ways of the set intact.
- R8: An update that misses replaces the least recently used way of the set. Lookup hits and writes both make a way most recently used.
- R9: When an update and a lookup occur in the same cycle, the lookup sees the contents from before the update, and the next lookup sees the new contents.
- R10: When a lookup hit and an allocating update reach the same set in one cycle, the victim is the way that was least recently used at the start of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lk_en_i | input | 1 | Lookup request |
| lk_pc_i | input | ADDR_W | Fetch PC to look up |
| upd_en_i | input | 1 | Update request |
| upd_pc_i | input | ADDR_W | Resolved branch PC |
| upd_tgt_i | input | ADDR_W | Resolved branch target |
| lk_hit_o | output | 1 | Registered prediction valid |
| lk_tgt_o | output | ADDR_W | Registered predicted target (zero on miss) |

## Verification
The hardest state to reach from the ports is a far entry whose primary half is still present while its secondary half has been evicted. To reach it, the stimulus writes one far branch and then four further far branches. These share its secondary set index but fall in a different primary set, so the secondary set overflows while the first primary entry survives. A second hard case is a lookup hit and an allocating update landing on the same set in one cycle. The stimulus drives both on one edge, so the choice of victim between the two recency orders is visible on later lookups. A behavioural model with per-way timestamps runs alongside the design and is compared on every cycle under long random traffic.

// File: rtl/btb_pkg.sv
package btb_pkg;
  parameter int unsigned BTB_ADDR_W = 30;
  typedef logic [BTB_ADDR_W-1:0] btb_addr_t;
endpackage

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int unsigned SETS = 8,
  parameter int unsigned WAYS = 2,
  localparam int unsigned IW = $clog2(SETS),
  localparam int unsigned AW = $clog2(WAYS)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          t0_en_i,
  input  logic [IW-1:0] t0_idx_i,
  input  logic [AW-1:0] t0_way_i,
  input  logic          t1_en_i,
  input  logic [IW-1:0] t1_idx_i,
  input  logic [AW-1:0] t1_way_i,
  input  logic [IW-1:0] vic_idx_i,
  output logic [AW-1:0] vic_way_o
);
  typedef logic [WAYS-1:0][AW-1:0] ages_t;

  ages_t age_q [SETS];
  ages_t age_d [SETS];
  int unsigned vic_cnt;

  function automatic ages_t touch(input ages_t a, input logic [AW-1:0] w);
    ages_t r;
    for (int i = 0; i < WAYS; i++) begin
      if (w == AW'(i))       r[i] = '0;
      else if (a[i] < a[w])  r[i] = a[i] + AW'(1);
      else                   r[i] = a[i];
    end
    return r;
  endfunction

  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      ages_t a;
      a = age_q[s];
      if (t0_en_i && t0_idx_i == IW'(s)) a = touch(a, t0_way_i);
      if (t1_en_i && t1_idx_i == IW'(s)) a = touch(a, t1_way_i);
      age_d[s] = a;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int s = 0; s < SETS; s++) begin
      if (rst_i) begin
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AW'(w);
      end else begin
        age_q[s] <= age_d[s];
      end
    end
  end

  always_comb begin
    vic_way_o = '0;
    vic_cnt   = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[vic_idx_i][w] == AW'(WAYS-1)) begin
        vic_way_o = AW'(w);
        vic_cnt   = vic_cnt + 1;
      end
    end
  end

  // R8
  lru_victim_unique_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    vic_cnt == 1);
endmodule

// File: rtl/btb_way_table.sv
module btb_way_table #(
  parameter int unsigned SETS   = 8,
  parameter int unsigned WAYS   = 2,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 10,
  localparam int unsigned IW = $clog2(SETS),
  localparam int unsigned WW = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [IW-1:0]     rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              rd_hit_o,
  output logic [WW-1:0]     rd_way_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [IW-1:0]     up_idx_i,
  input  logic [TAG_W-1:0]  up_tag_i,
  output logic              up_hit_o,
  output logic [WW-1:0]     up_way_o,
  input  logic              wr_en_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic [WW-1:0]     wr_way_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [SETS-1:0][WAYS-1:0] valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [WAYS-1:0]   rd_match;
  logic [WAYS-1:0]   up_match;

  for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
    assign rd_match[gw] = valid_q[rd_idx_i][gw] && (tag_q[rd_idx_i][gw] == rd_tag_i);
    assign up_match[gw] = valid_q[up_idx_i][gw] && (tag_q[up_idx_i][gw] == up_tag_i);
  end

  always_comb begin
    rd_way_o = '0;
    up_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (rd_match[w]) rd_way_o = WW'(w);
      if (up_match[w]) up_way_o = WW'(w);
    end
  end

  assign rd_hit_o  = |rd_match;
  assign up_hit_o  = |up_match;
  assign rd_data_o = data_q[rd_idx_i][rd_way_o];

  always_ff @(posedge clk_i) begin
    if (rst_i)        valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i][wr_way_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i][wr_way_i]  <= wr_tag_i;
      data_q[wr_idx_i][wr_way_i] <= wr_data_i;
    end
  end

  // R7
  dup_tag_rd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(rd_match));
  // R7
  dup_tag_up_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(up_match));
endmodule

// File: rtl/btb_split_target.sv
module btb_split_target
  import btb_pkg::*;
#(
  parameter int unsigned ADDR_W  = BTB_ADDR_W,
  parameter int unsigned LO_W    = 9,
  parameter int unsigned P_SETS  = 8,
  parameter int unsigned P_WAYS  = 2,
  parameter int unsigned P_TAG_W = 6,
  parameter int unsigned S_SETS  = 4,
  parameter int unsigned S_WAYS  = 4,
  parameter int unsigned S_TAG_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              lk_en_i,
  input  logic [ADDR_W-1:0] lk_pc_i,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic [ADDR_W-1:0] upd_tgt_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_tgt_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W;
  localparam int unsigned PIW  = $clog2(P_SETS);
  localparam int unsigned PWW  = $clog2(P_WAYS);
  localparam int unsigned SIW  = $clog2(S_SETS);
  localparam int unsigned SWW  = $clog2(S_WAYS);

  // lookup side fields
  logic [PIW-1:0]     lk_pidx;
  logic [P_TAG_W-1:0] lk_ptag;
  logic [SIW-1:0]     lk_sidx;
  logic [S_TAG_W-1:0] lk_stag;
  assign lk_pidx = lk_pc_i[PIW-1:0];
  assign lk_ptag = lk_pc_i[PIW +: P_TAG_W];
  assign lk_sidx = lk_pc_i[SIW-1:0];
  assign lk_stag = lk_pc_i[SIW +: S_TAG_W];

  // update side fields
  logic [PIW-1:0]     up_pidx;
  logic [P_TAG_W-1:0] up_ptag;
  logic [SIW-1:0]     up_sidx;
  logic [S_TAG_W-1:0] up_stag;
  logic               up_far;
  assign up_pidx = upd_pc_i[PIW-1:0];
  assign up_ptag = upd_pc_i[PIW +: P_TAG_W];
  assign up_sidx = upd_pc_i[SIW-1:0];
  assign up_stag = upd_pc_i[SIW +: S_TAG_W];
  assign up_far  = upd_tgt_i[ADDR_W-1:LO_W] != upd_pc_i[ADDR_W-1:LO_W];

  // primary table: payload is {far, low target bits}
  logic           p_rd_hit, p_up_hit;
  logic [PWW-1:0] p_rd_way, p_up_way, p_vic, p_wway;
  logic [LO_W:0]  p_rd_data;
  logic           p_far;
  logic [LO_W-1:0] p_lo;
  assign p_far  = p_rd_data[LO_W];
  assign p_lo   = p_rd_data[LO_W-1:0];
  assign p_wway = p_up_hit ? p_up_way : p_vic;

  btb_way_table #(
    .SETS(P_SETS), .WAYS(P_WAYS), .TAG_W(P_TAG_W), .DATA_W(LO_W + 1)
  ) u_ptab (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rd_idx_i  (lk_pidx),
    .rd_tag_i  (lk_ptag),
    .rd_hit_o  (p_rd_hit),
    .rd_way_o  (p_rd_way),
    .rd_data_o (p_rd_data),
    .up_idx_i  (up_pidx),
    .up_tag_i  (up_ptag),
    .up_hit_o  (p_up_hit),
    .up_way_o  (p_up_way),
    .wr_en_i   (upd_en_i),
    .wr_idx_i  (up_pidx),
    .wr_way_i  (p_wway),
    .wr_tag_i  (up_ptag),
    .wr_data_i ({up_far, upd_tgt_i[LO_W-1:0]})
  );

  // secondary table: payload is the high target bits
  logic            s_rd_hit, s_up_hit;
  logic [SWW-1:0]  s_rd_way, s_up_way, s_vic, s_wway;
  logic [HI_W-1:0] s_hi;
  logic            s_wr_en;
  assign s_wway  = s_up_hit ? s_up_way : s_vic;
  assign s_wr_en = upd_en_i && up_far;

  btb_way_table #(
    .SETS(S_SETS), .WAYS(S_WAYS), .TAG_W(S_TAG_W), .DATA_W(HI_W)
  ) u_stab (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rd_idx_i  (lk_sidx),
    .rd_tag_i  (lk_stag),
    .rd_hit_o  (s_rd_hit),
    .rd_way_o  (s_rd_way),
    .rd_data_o (s_hi),
    .up_idx_i  (up_sidx),
    .up_tag_i  (up_stag),
    .up_hit_o  (s_up_hit),
    .up_way_o  (s_up_way),
    .wr_en_i   (s_wr_en),
    .wr_idx_i  (up_sidx),
    .wr_way_i  (s_wway),
    .wr_tag_i  (up_stag),
    .wr_data_i (upd_tgt_i[ADDR_W-1:LO_W])
  );

  // prediction assembly
  logic              full_hit;
  logic [ADDR_W-1:0] tgt_d;
  assign full_hit = lk_en_i && p_rd_hit && (!p_far || s_rd_hit);
  assign tgt_d    = !full_hit ? '0 :
                    p_far     ? {s_hi, p_lo} : {lk_pc_i[ADDR_W-1:LO_W], p_lo};

  // recency tracking: port 0 = lookup hit, port 1 = update write
  btb_lru #(.SETS(P_SETS), .WAYS(P_WAYS)) u_plru (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .t0_en_i   (full_hit),
    .t0_idx_i  (lk_pidx),
    .t0_way_i  (p_rd_way),
    .t1_en_i   (upd_en_i),
    .t1_idx_i  (up_pidx),
    .t1_way_i  (p_wway),
    .vic_idx_i (up_pidx),
    .vic_way_o (p_vic)
  );

  btb_lru #(.SETS(S_SETS), .WAYS(S_WAYS)) u_slru (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .t0_en_i   (full_hit && p_far),
    .t0_idx_i  (lk_sidx),
    .t0_way_i  (s_rd_way),
    .t1_en_i   (s_wr_en),
    .t1_idx_i  (up_sidx),
    .t1_way_i  (s_wway),
    .vic_idx_i (up_sidx),
    .vic_way_o (s_vic)
  );

  // output registers
  logic hit_q, far_q;
  logic [ADDR_W-1:0] tgt_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hit_q <= 1'b0;
      far_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      hit_q <= full_hit;
      far_q <= full_hit && p_far;
      tgt_q <= tgt_d;
    end
  end
  assign lk_hit_o = hit_q;
  assign lk_tgt_o = tgt_q;

  // R1
  reset_miss_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> !lk_hit_o);
  // R2
  hit_needs_lookup_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    lk_hit_o |-> $past(lk_en_i));
  // R3
  near_high_part_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (lk_hit_o && !far_q) |-> (lk_tgt_o[ADDR_W-1:LO_W] == $past(lk_pc_i[ADDR_W-1:LO_W])));
endmodule

// File: tb/btb_split_target_bench.sv
module btb_split_target_bench;
  localparam int A   = 30;
  localparam int LO  = 9;
  localparam int PS  = 8;
  localparam int PW  = 2;
  localparam int PT  = 6;
  localparam int SS  = 4;
  localparam int SW  = 4;
  localparam int ST  = 6;
  localparam int PIW = 3;
  localparam int SIW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_en = 1'b0, upd_en = 1'b0;
  logic [A-1:0] lk_pc = '0, upd_pc = '0, upd_tgt = '0;
  logic lk_hit;
  logic [A-1:0] lk_tgt;

  always #4 clk = ~clk;

  btb_split_target #(
    .ADDR_W(A), .LO_W(LO), .P_SETS(PS), .P_WAYS(PW), .P_TAG_W(PT),
    .S_SETS(SS), .S_WAYS(SW), .S_TAG_W(ST)
  ) u_btb_split_target (
    .clk_i(clk), .rst_i(rst), .lk_en_i(lk_en), .lk_pc_i(lk_pc),
    .upd_en_i(upd_en), .upd_pc_i(upd_pc), .upd_tgt_i(upd_tgt),
    .lk_hit_o(lk_hit), .lk_tgt_o(lk_tgt)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // behavioural reference: per-way contents plus last-use timestamps
  bit            m_pv  [PS][PW];
  bit [PT-1:0]   m_ptg [PS][PW];
  bit [LO-1:0]   m_plo [PS][PW];
  bit            m_pf  [PS][PW];
  int            m_pts [PS][PW];
  bit            m_sv  [SS][SW];
  bit [ST-1:0]   m_stg [SS][SW];
  bit [A-LO-1:0] m_shi [SS][SW];
  int            m_sts [SS][SW];
  int            tick = 0;
  bit            exp_hit;
  logic [A-1:0]  exp_tgt;
  string         exp_req;

  task automatic check(string req, bit gh, bit eh, logic [A-1:0] gt, logic [A-1:0] et);
    n_chk++;
    if (gh !== eh || gt !== et) begin
      n_fail++;
      $display("FAIL %s: hit=%0b tgt=%h expected hit=%0b tgt=%h", req, gh, gt, eh, et);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < PS; s++)
      for (int w = 0; w < PW; w++) begin m_pv[s][w] = 0; m_pts[s][w] = -1 - w; end
    for (int s = 0; s < SS; s++)
      for (int w = 0; w < SW; w++) begin m_sv[s][w] = 0; m_sts[s][w] = -1 - w; end
  endtask

  task automatic model(bit r, bit le, logic [A-1:0] lpc, bit ue, logic [A-1:0] upc, logic [A-1:0] utg);
    int pi, si, pw, sw, ui, usi, uw, usw;
    bit h, uf;
    logic [A-1:0] t;
    if (r) begin
      model_clear();
      exp_hit = 0; exp_tgt = '0; exp_req = "R1";
      return;
    end
    pi = int'(lpc[PIW-1:0]); si = int'(lpc[SIW-1:0]);
    pw = -1; sw = -1; h = 0; t = '0;
    for (int w = 0; w < PW; w++) if (m_pv[pi][w] && m_ptg[pi][w] == lpc[PIW +: PT]) pw = w;
    if (pw >= 0) begin
      if (!m_pf[pi][pw]) begin
        h = 1; t = {lpc[A-1:LO], m_plo[pi][pw]};
      end else begin
        for (int w = 0; w < SW; w++) if (m_sv[si][w] && m_stg[si][w] == lpc[SIW +: ST]) sw = w;
        if (sw >= 0) begin h = 1; t = {m_shi[si][sw], m_plo[pi][pw]}; end
      end
    end
    exp_hit = le && h;
    exp_tgt = exp_hit ? t : '0;
    if (!le)                        exp_req = "R2";
    else if (h && pw >= 0 && m_pf[pi][pw]) exp_req = "R4";
    else if (h)                     exp_req = "R3";
    else if (pw >= 0)               exp_req = "R5";
    else                            exp_req = "R2";
    // victims use the order at the start of the cycle (R10)
    ui = int'(upc[PIW-1:0]); usi = int'(upc[SIW-1:0]);
    uf = upc[A-1:LO] != utg[A-1:LO];
    uw = -1; usw = -1;
    for (int w = 0; w < PW; w++) if (m_pv[ui][w] && m_ptg[ui][w] == upc[PIW +: PT]) uw = w;
    if (uw < 0) begin
      uw = 0;
      for (int w = 1; w < PW; w++) if (m_pts[ui][w] < m_pts[ui][uw]) uw = w;
    end
    for (int w = 0; w < SW; w++) if (m_sv[usi][w] && m_stg[usi][w] == upc[SIW +: ST]) usw = w;
    if (usw < 0) begin
      usw = 0;
      for (int w = 1; w < SW; w++) if (m_sts[usi][w] < m_sts[usi][usw]) usw = w;
    end
    if (le && h) begin
      m_pts[pi][pw] = tick; tick++;
      if (m_pf[pi][pw]) begin m_sts[si][sw] = tick; tick++; end
    end
    if (ue) begin
      m_pv[ui][uw] = 1; m_ptg[ui][uw] = upc[PIW +: PT];
      m_plo[ui][uw] = utg[LO-1:0]; m_pf[ui][uw] = uf;
      m_pts[ui][uw] = tick; tick++;
      if (uf) begin
        m_sv[usi][usw] = 1; m_stg[usi][usw] = upc[SIW +: ST];
        m_shi[usi][usw] = utg[A-1:LO];
        m_sts[usi][usw] = tick; tick++;
      end
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(bit r, bit le, logic [A-1:0] lpc, bit ue, logic [A-1:0] upc, logic [A-1:0] utg);
    rst = r; lk_en = le; lk_pc = lpc; upd_en = ue; upd_pc = upc; upd_tgt = utg;
    model(r, le, lpc, ue, upc, utg);
    @(negedge clk);
    check(exp_req, lk_hit, exp_hit, lk_tgt, exp_tgt);
  endtask

  task automatic upd(logic [A-1:0] pc, logic [A-1:0] tg);
    step(0, 0, '0, 1, pc, tg);
  endtask
  task automatic look(logic [A-1:0] pc);
    step(0, 1, pc, 0, '0, '0);
  endtask

  function automatic logic [A-1:0] pc_of(int hi, int tag, int idx);
    return (A'(hi) << LO) | (A'(tag) << PIW) | A'(idx);
  endfunction
  function automatic logic [A-1:0] near(logic [A-1:0] pc, int lo);
    return {pc[A-1:LO], LO'(lo)};
  endfunction

  initial begin
    logic [A-1:0] pool [24];
    logic [A-1:0] xa, xb, xc;
    for (int i = 0; i < 4; i++) step(1, 0, '0, 0, '0, '0);

    // R1: empty after reset
    xa = pc_of(4, 1, 3);
    look(xa);
    check("R1", lk_hit, 0, lk_tgt, '0);

    // R7 overwrite in place, R3 near rebuild
    xb = pc_of(4, 2, 3);
    upd(xa, near(xa, 'h011));
    upd(xb, near(xb, 'h022));
    upd(xa, near(xa, 'h033));
    look(xb);
    check("R7", lk_hit, 1, lk_tgt, near(xb, 'h022));
    look(xa);
    check("R3", lk_hit, 1, lk_tgt, near(xa, 'h033));

    // R6 partial tag: bits above the tag alias
    xc = pc_of(9, 1, 3);
    look(xc);
    check("R6", lk_hit, 1, lk_tgt, near(xc, 'h033));

    // R4 far target
    xa = pc_of(6, 5, 6);
    xb = pc_of(40, 0, 0) | A'('h1AB);
    upd(xa, xb);
    look(xa);
    check("R4", lk_hit, 1, lk_tgt, xb);

    // R2 lookup disabled
    step(0, 0, xa, 0, '0, '0);
    check("R2", lk_hit, 0, lk_tgt, '0);

    // R9 same-cycle update and lookup
    xa = pc_of(5, 1, 5);
    step(0, 1, xa, 1, xa, near(xa, 'h0AA));
    check("R9", lk_hit, 0, lk_tgt, '0);
    look(xa);
    check("R9", lk_hit, 1, lk_tgt, near(xa, 'h0AA));

    // R8 LRU with lookup refresh
    xa = pc_of(2, 1, 1); xb = pc_of(2, 2, 1); xc = pc_of(2, 3, 1);
    upd(xa, near(xa, 1));
    upd(xb, near(xb, 2));
    look(xa);
    upd(xc, near(xc, 3));
    look(xb);
    check("R8", lk_hit, 0, lk_tgt, '0);
    look(xa);
    check("R8", lk_hit, 1, lk_tgt, near(xa, 1));

    // R10 victim taken from the order before the same-cycle hit
    xa = pc_of(3, 1, 2); xb = pc_of(3, 2, 2); xc = pc_of(3, 3, 2);
    upd(xa, near(xa, 4));
    upd(xb, near(xb, 5));
    step(0, 1, xa, 1, xc, near(xc, 6));
    check("R10", lk_hit, 1, lk_tgt, near(xa, 4));
    look(xa);
    check("R10", lk_hit, 0, lk_tgt, '0);
    look(xb);
    check("R10", lk_hit, 1, lk_tgt, near(xb, 5));

    // R5 secondary half evicted while primary half survives
    xa = pc_of(1, 0, 0);
    xb = pc_of(50, 0, 0) | A'(5);
    upd(xa, xb);
    look(xa);
    check("R4", lk_hit, 1, lk_tgt, xb);
    for (int t = 1; t <= 4; t++) upd(pc_of(1, t, 4), pc_of(50 + t, 0, 0));
    look(xa);
    check("R5", lk_hit, 0, lk_tgt, '0);

    // random traffic against the model
    for (int i = 0; i < 24; i++)
      pool[i] = pc_of(($urandom % 2) ? 7 : 1, int'($urandom % 4), int'($urandom % 8));
    for (int i = 0; i < 6000; i++) begin
      logic [A-1:0] p, q, g;
      p = pool[$urandom % 24];
      q = pool[$urandom % 24];
      if ($urandom % 2) g = near(q, int'($urandom % 512));
      else              g = pc_of(17 * (1 + int'($urandom % 3)), 0, 0) | A'($urandom % 512);
      if (i >= 3000 && i < 3003) step(1, 1, p, 1, q, g);
      else step(0, ($urandom % 4) != 0, p, ($urandom % 3) == 0, q, g);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule